// File: doc/BRIEF.md
# Multi-Context Folding Logic Element

This block is a single logic element built around one 4-input look-up table. It holds sixteen configuration words locally and can switch between them as often as every clock cycle. A deep combinational network is split into a chain of small functions, one per context. The element works through that chain on successive cycles, and a flip-flop carries each partial result forward to the next function. The same hardware therefore evaluates a long chain at the cost of extra cycles.

Configuration words are loaded through a write port while the element is idle. A start pulse launches one folded computation. The launch captures the folding level, which sets how many evaluations are made per context, and the number of contexts in the chain. A one-cycle completion pulse marks the end of the computation. The output shows either the live look-up result or the flip-flop, as chosen by the active configuration word. When idle, context 0 is the active word.

Top module: `fold_le`

## Requirements
- R1: After synchronous reset, every stored word is all zero (truth table 0, combinational output), the flip-flop holds 0, and `y`, `done` and `cfg_err` are 0.
- R2: A word is 17 bits. Bits 15:0 are the truth table and bit 16 selects the output (1 gives the flip-flop, 0 gives the live look-up value). The look-up index is {lut_in[3], lut_in[2], lut_in[1], lut_in[0]}, and the look-up value is table[index]. `y` follows the word of the active context, which is context 0 while idle.
- R3: `fold_level` encodings are 2'b00 (no folding: a single evaluation of context 0), 2'b01 (one evaluation per context), 2'b10 (two evaluations) and 2'b11 (four evaluations). The context index advances only after that many evaluations.
- R4: `ctx_len` (1 to 16, with 16 written as 5'd16) is captured at start. A folded run uses contexts 0 through ctx_len-1 in ascending order and then returns to context 0.
- R5: During a run, the flip-flop loads the look-up value on every cycle. `done` is high for exactly one cycle. It rises in the cycle after the final evaluation, ctx_len × evaluations-per-context clock edges after the edge that sampled start (one edge with no folding).
- R6: A start pulse that arrives during a run has no effect on the run's sequence, its length or its result.
- R7: A configuration write made while idle is stored at `cfg_idx`. A write made during a run is discarded, and `cfg_err` goes high for one cycle, on the cycle after the edge that sampled the write.
- R8: With `fb_sel` high, the flip-flop output takes the place of lut_in[0] in the look-up index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Context slot to write |
| cfg_word | input | 17 | Configuration word: output select in bit 16, truth table in bits 15:0 |
| start | input | 1 | Launches a folded run when idle |
| fold_level | input | 2 | Evaluations per context, captured at start |
| ctx_len | input | 5 | Number of contexts in the run, captured at start |
| fb_sel | input | 1 | Route flip-flop output into look-up input 0 |
| lut_in | input | 4 | External look-up inputs |
| y | output | 1 | Element output, registered or combinational per word |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle flag for a discarded configuration write |

## Verification
The assertions assume that `ctx_len` lies between 1 and 16 whenever start is sampled. They also assume that `fold_level` and `ctx_len` matter only at that sampling edge. The stimulus meets this by driving lengths only from that range and by changing those inputs only while idle, before the start pulse. The discarded-write property assumes that a write during a run is a single strobe. The stimulus raises `cfg_we` for exactly one cycle in the middle of a run and then observes `cfg_err` and the output that the dropped word would have altered.

// File: rtl/fold_pkg.sv
package fold_pkg;

    localparam int LUT_K  = 4;
    localparam int TT_W   = 1 << LUT_K;
    localparam int WORD_W = TT_W + 1;

    typedef enum logic [1:0] {
        FOLD_NONE = 2'b00,
        FOLD_P1   = 2'b01,
        FOLD_P2   = 2'b10,
        FOLD_P4   = 2'b11
    } fold_lvl_e;

    // bit 16 selects registered output, bits 15:0 hold the truth table
    typedef struct packed {
        logic            reg_out;
        logic [TT_W-1:0] tt;
    } cfg_word_t;

    // evaluations per context, minus one
    function automatic logic [1:0] evals_m1(fold_lvl_e lvl);
        case (lvl)
            FOLD_P2: return 2'd1;
            FOLD_P4: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fold_cfg_bank.sv
module fold_cfg_bank
    import fold_pkg::*;
#(
    parameter int CTX_NUM = 16,
    localparam int CTX_W  = $clog2(CTX_NUM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             lock,
    input  logic [CTX_W-1:0] widx,
    input  cfg_word_t        wdata,
    input  logic [CTX_W-1:0] ridx,
    output cfg_word_t        rdata,
    output logic             drop
);

    cfg_word_t [CTX_NUM-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem  <= '0;
            drop <= 1'b0;
        end else begin
            drop <= we && lock;
            if (we && !lock)
                mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

    assert_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
        (we && lock) |=> $stable(mem));

endmodule

// File: rtl/fold_seq.sv
module fold_seq
    import fold_pkg::*;
#(
    parameter int CTX_NUM = 16,
    localparam int CTX_W  = $clog2(CTX_NUM),
    localparam int LEN_W  = $clog2(CTX_NUM + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  fold_lvl_e        level,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic [CTX_W-1:0] ctx,
    output logic             done
);

    logic [1:0]       pcnt;
    logic [1:0]       pmax;
    logic [CTX_W-1:0] last_ctx;
    fold_lvl_e        lvl_q;
    logic             step_end;
    logic             run_end;

    assign step_end = (pcnt == pmax);
    assign run_end  = step_end && (ctx == last_ctx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            ctx      <= '0;
            pcnt     <= '0;
            pmax     <= '0;
            last_ctx <= '0;
            lvl_q    <= FOLD_NONE;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    ctx      <= '0;
                    pcnt     <= '0;
                    pmax     <= evals_m1(level);
                    lvl_q    <= level;
                    last_ctx <= (level == FOLD_NONE) ? '0 : CTX_W'(len - LEN_W'(1));
                end
            end else if (step_end) begin
                pcnt <= '0;
                if (ctx == last_ctx) begin
                    busy <= 1'b0;
                    ctx  <= '0;
                    done <= 1'b1;
                end else begin
                    ctx <= ctx + CTX_W'(1);
                end
            end else begin
                pcnt <= pcnt + 2'd1;
            end
        end
    end

    assert_pcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> pcnt <= pmax);

    assert_nofold_ctx0_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && lvl_q == FOLD_NONE) |-> ctx == '0);

    assert_p1_step_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && lvl_q == FOLD_P1 && ctx != last_ctx) |=> ctx == $past(ctx) + CTX_W'(1));

    assert_ctx_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctx <= last_ctx);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !step_end) |=> busy && ctx == $past(ctx) && pcnt == $past(pcnt) + 2'd1);

endmodule

// File: rtl/fold_lut_cell.sv
module fold_lut_cell
    import fold_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cfg_word_t        word,
    input  logic [LUT_K-1:0] lut_in,
    input  logic             fb_sel,
    output logic             y
);

    logic             q;
    logic [LUT_K-1:0] idx;
    logic             f;

    assign idx = {lut_in[LUT_K-1:1], (fb_sel ? q : lut_in[0])};
    assign f   = word.tt[idx];

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (en)
            q <= f;
    end

    assign y = word.reg_out ? q : f;

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/fold_le.sv
module fold_le
    import fold_pkg::*;
#(
    parameter int CTX_NUM = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [$clog2(CTX_NUM)-1:0]   cfg_idx,
    input  logic [WORD_W-1:0]            cfg_word,
    input  logic                         start,
    input  logic [1:0]                   fold_level,
    input  logic [$clog2(CTX_NUM+1)-1:0] ctx_len,
    input  logic                         fb_sel,
    input  logic [LUT_K-1:0]             lut_in,
    output logic                         y,
    output logic                         done,
    output logic                         cfg_err
);

    localparam int CTX_W = $clog2(CTX_NUM);

    logic             busy;
    logic [CTX_W-1:0] ctx;
    cfg_word_t        active;

    fold_seq #(.CTX_NUM(CTX_NUM)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .level (fold_lvl_e'(fold_level)),
        .len   (ctx_len),
        .busy  (busy),
        .ctx   (ctx),
        .done  (done)
    );

    fold_cfg_bank #(.CTX_NUM(CTX_NUM)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .lock  (busy),
        .widx  (cfg_idx),
        .wdata (cfg_word_t'(cfg_word)),
        .ridx  (ctx),
        .rdata (active),
        .drop  (cfg_err)
    );

    fold_lut_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .en     (busy),
        .word   (active),
        .lut_in (lut_in),
        .fb_sel (fb_sel),
        .y      (y)
    );

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_we && busy));

    assert_idle_ctx0_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ctx == '0);

endmodule

// File: tb/sim_fold_le.sv
`timescale 1ns/1ps
module sim_fold_le;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [16:0] cfg_word = '0;
    logic        start = 1'b0;
    logic [1:0]  fold_level = '0;
    logic [4:0]  ctx_len = 5'd1;
    logic        fb_sel = 1'b0;
    logic [3:0]  lut_in = '0;
    logic        y, done, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic        mr = 1'b0;
    logic [15:0] tt_mem [16];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fold_le u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
        .start(start), .fold_level(fold_level), .ctx_len(ctx_len), .fb_sel(fb_sel),
        .lut_in(lut_in), .y(y), .done(done), .cfg_err(cfg_err)
    );

    // {lvl[1:0], len[4:0], fb, in[3:0], seed[7:0]}
    localparam int NSCN = 9;
    localparam logic [19:0] SCN [NSCN] = '{
        {2'd1, 5'd1,  1'b0, 4'h5, 8'h11},
        {2'd1, 5'd4,  1'b1, 4'hA, 8'h22},
        {2'd2, 5'd3,  1'b0, 4'h3, 8'h33},
        {2'd3, 5'd2,  1'b1, 4'hF, 8'h44},
        {2'd0, 5'd9,  1'b0, 4'h6, 8'h55},
        {2'd1, 5'd16, 1'b1, 4'h0, 8'h66},
        {2'd3, 5'd16, 1'b0, 4'h9, 8'h77},
        {2'd2, 5'd7,  1'b1, 4'hC, 8'h88},
        {2'd0, 5'd1,  1'b1, 4'hE, 8'h99}
    };

    function automatic logic [15:0] ttf(int c, logic [7:0] s);
        int v;
        v = int'(s) * 40503 + c * 15133 + (c << s[2:0]);
        return 16'(v ^ (v >> 7));
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [16:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        tt_mem[idx] = w[15:0];
    endtask

    // bench model of one folded run; returns expected edge count
    task automatic model(input logic [1:0] lvl, input int len, input logic fb,
                         input logic [3:0] in, output int cycles);
        int nctx, p;
        logic [3:0] ix;
        nctx = (lvl == 2'd0) ? 1 : len;
        p = (lvl == 2'd2) ? 2 : (lvl == 2'd3) ? 4 : 1;
        for (int c = 0; c < nctx; c++)
            for (int k = 0; k < p; k++) begin
                ix = {in[3:1], (fb ? mr : in[0])};
                mr = tt_mem[c][ix];
            end
        cycles = nctx * p;
    endtask

    // inj: 0 none, 1 extra start at cycle at, 2 locked write at cycle at
    task automatic run(input logic [1:0] lvl, input int len, input logic fb,
                       input logic [3:0] in, input logic [7:0] seed,
                       input int inj, input int at, input string rq);
        int exp_cyc, j;
        for (int c = 0; c < 16; c++) wr(c, {1'b1, ttf(c, seed)});
        @(negedge clk);
        fold_level = lvl; ctx_len = 5'(len); fb_sel = fb; lut_in = in;
        model(lvl, len, fb, in, exp_cyc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        j = 0;
        while (!done && j < 300) begin
            if (inj == 1 && j == at) start = 1'b1;
            if (inj == 2 && j == at) begin
                cfg_we = 1'b1; cfg_idx = 4'd0; cfg_word = {1'b0, {16{~mr}}};
            end
            @(negedge clk);
            j++;
            start = 1'b0;
            if (inj == 2 && j == at + 1) begin
                cfg_we = 1'b0;
                chk("R7 err raised", 32'(cfg_err), 32'd1);
            end
            if (inj == 2 && j == at + 2) chk("R7 err one cycle", 32'(cfg_err), 32'd0);
        end
        chk({rq, " R5 run length"}, 32'(j), 32'(exp_cyc));
        chk({rq, " R4 result"}, 32'(y), 32'(mr));
        @(negedge clk);
        chk("R5 done one cycle", 32'(done), 32'd0);
        chk({rq, " R2 idle output held"}, 32'(y), 32'(mr));
    endtask

    initial begin
        for (int c = 0; c < 16; c++) tt_mem[c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 y", 32'(y), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 cfg_err", 32'(cfg_err), 32'd0);
        for (int v = 0; v < 16; v += 5) begin
            lut_in = 4'(v); #1;
            chk("R1 zero table", 32'(y), 32'd0);
        end
        // R2: combinational word, index order
        wr(0, {1'b0, 16'hA5C3});
        chk("R7 idle write no err", 32'(cfg_err), 32'd0);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            lut_in = 4'(v); #1;
            chk("R2 comb lookup", 32'(y), 32'(tt_mem[0][v]));
        end
        // R3 R4 R5 R8: table walk
        for (int s = 0; s < NSCN; s++)
            run(SCN[s][19:18], int'(SCN[s][17:13]), SCN[s][12], SCN[s][11:8], SCN[s][7:0],
                0, 0, "R3 R8 table");
        // R6: start during run ignored
        run(2'd2, 5, 1'b1, 4'h7, 8'hA1, 1, 3, "R6 restart");
        // R7: write during run dropped
        run(2'd3, 16, 1'b0, 4'hB, 8'hB2, 2, 4, "R7 locked write");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule